// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block turns a memory-mapped read request into one complete read transaction on a serial NOR flash. A host presents a word address with a valid/ready handshake. The sequencer requests chip select and sends an opcode byte and then the byte address. It may then run a number of dummy clocks before it shifts in four data bytes. It returns them as one 32-bit word together with a one-cycle response strobe.

A set of configuration inputs chooses one of eight read modes. These are standard, fast, dual-output, dual-I/O, quad-output, quad-I/O and two custom modes. The inputs also set the address width, the dummy clock count, the serial clock divider and the clock idle level. The custom modes add a programmable opcode and a separate 1/2/4-line width for each of the opcode, address and data phases. The configuration is captured when a request is accepted. It can change freely while a transaction is running.

Top module: `flash_read_seq`

## Requirements
- R1: Out of reset and between transactions, `cs_req` is 0, `req_ready` is 1, `io_oe` is 0 and `sck` rests at `cfg_idle_high` (0 gives SPI mode 0, 1 gives SPI mode 3).
- R2: Every serial beat lasts D system cycles, where D = `cfg_div` + 1 and a field of 0 acts as 1 (D = 2). `sck` is low for the first floor(D/2) cycles of a beat and high for the rest. The response strobe rises exactly (total beats × D) cycles after the accepting clock edge.
- R3: In modes 0 to 5 the opcode is 0x03, 0x0B, 0x3B, 0xBB, 0x6B or 0xEB, in that mode order. It is sent MSB first on line 0 with only `io_oe[0]` set.
- R4: When the address width is 32 bits (`cfg_addr_sz` = 3) and `cfg_wide_op` is 1, modes 0 to 5 send 0x13, 0x0C, 0x3C, 0xBC, 0x6C or 0xEC instead.
- R5: The address is the byte address `{req_waddr, 2'b00}`, cut to 8, 16, 24 or 32 bits for `cfg_addr_sz` = 0, 1, 2 or 3, and sent MSB first.
- R6: Phase widths are as follows. Mode 2 has 2-line data. Mode 3 has 2-line address and data. Mode 4 has 4-line data. Mode 5 has 4-line address and data. All other phases use 1 line. On a multi-line beat, line 0 carries the least significant bit of the bit pair or nibble, and every driving line has its `io_oe` bit set.
- R7: Modes 1 to 5 and 7 insert `cfg_dummy` + 3 dummy beats (3 to 18) after the address. Modes 0 and 6 insert none. `io_oe` is 0 from the first dummy beat to the end of the transaction.
- R8: Modes 6 and 7 send `cfg_opcode` unchanged. The opcode, address and data phases use the line codes `cfg_ins_ln`, `cfg_adr_ln` and `cfg_dat_ln`: 0 means 1 line, 1 means 2 lines, and 2 or 3 mean 4 lines. Mode 7 adds dummy beats and mode 6 does not.
- R9: Data is sampled in the last system cycle of each beat (while `sck` is high). It is taken from `io_in[1]` on one line, `io_in[1:0]` on two and `io_in[3:0]` on four, MSB first. The first byte received becomes `rsp_data[7:0]` and the fourth becomes `rsp_data[31:24]`.
- R10: `rsp_valid` is high for exactly one cycle. In that cycle `cs_req` is already 0 and `req_ready` is 1.
- R11: Configuration and address are sampled only at acceptance. Changes to them, and requests presented while busy, do not alter a transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Read mode 0..7 |
| cfg_addr_sz | input | 2 | Address width: 8/16/24/32 bits |
| cfg_wide_op | input | 1 | Use 4-byte-address opcodes at 32-bit width |
| cfg_dummy | input | 4 | Dummy beats minus 3 |
| cfg_div | input | DIV_W (6) | Clock divisor minus 1 |
| cfg_idle_high | input | 1 | Serial clock idle level |
| cfg_opcode | input | 8 | Custom-mode opcode |
| cfg_ins_ln | input | 2 | Custom opcode line code |
| cfg_adr_ln | input | 2 | Custom address line code |
| cfg_dat_ln | input | 2 | Custom data line code |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_waddr | input | WADDR_W (30) | Word address |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Read word |
| sck | output | 1 | Serial clock |
| cs_req | output | 1 | Chip-select request |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The bench builds the block with its default parameters: a 30-bit word address and a 6-bit divider field. This lets it reach full 32-bit byte addresses, the 4-byte opcode substitution and the slowest divider setting of 64. Each mode runs at least once, with address widths of 8 to 32 bits, dummy counts at both ends of the range, an odd divisor and the zero divider field. The opcode, address and dummy beats are recorded on each serial clock rise and compared bit by bit. A flash model in the bench feeds the data beats.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_INSTR = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DUMMY = 3'd3,
        PH_DATA  = 3'd4
    } phase_e;

    // configuration captured at request acceptance (divider kept apart)
    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] addr_sz;
        logic       wide_op;
        logic [3:0] dummy;
        logic [7:0] opcode;
        logic [1:0] ins_ln;
        logic [1:0] adr_ln;
        logic [1:0] dat_ln;
    } cfg_t;

    // per-transaction plan derived from the configuration
    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] ins_lg;     // log2 of lines
        logic [1:0] adr_lg;
        logic [1:0] dat_lg;
        logic       has_dummy;
        logic [5:0] addr_bits;  // 8..32
    } plan_t;

    function automatic logic [1:0] ln_to_lg(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/fsq_mode_decode.sv
module fsq_mode_decode
    import fsq_pkg::*;
(
    input  cfg_t  cfg,
    output plan_t plan
);
    logic wide;

    always_comb begin
        wide           = cfg.wide_op && (cfg.addr_sz == 2'd3);
        plan           = '0;
        plan.addr_bits = 6'({cfg.addr_sz, 3'b000}) + 6'd8;
        unique case (cfg.mode)
            3'd0: plan.opcode = wide ? 8'h13 : 8'h03;
            3'd1: begin
                plan.opcode    = wide ? 8'h0C : 8'h0B;
                plan.has_dummy = 1'b1;
            end
            3'd2: begin
                plan.opcode    = wide ? 8'h3C : 8'h3B;
                plan.dat_lg    = 2'd1;
                plan.has_dummy = 1'b1;
            end
            3'd3: begin
                plan.opcode    = wide ? 8'hBC : 8'hBB;
                plan.adr_lg    = 2'd1;
                plan.dat_lg    = 2'd1;
                plan.has_dummy = 1'b1;
            end
            3'd4: begin
                plan.opcode    = wide ? 8'h6C : 8'h6B;
                plan.dat_lg    = 2'd2;
                plan.has_dummy = 1'b1;
            end
            3'd5: begin
                plan.opcode    = wide ? 8'hEC : 8'hEB;
                plan.adr_lg    = 2'd2;
                plan.dat_lg    = 2'd2;
                plan.has_dummy = 1'b1;
            end
            default: begin  // custom standard (6) / custom fast (7)
                plan.opcode    = cfg.opcode;
                plan.ins_lg    = ln_to_lg(cfg.ins_ln);
                plan.adr_lg    = ln_to_lg(cfg.adr_ln);
                plan.dat_lg    = ln_to_lg(cfg.dat_ln);
                plan.has_dummy = cfg.mode[0];
            end
        endcase
    end
endmodule

// File: rtl/fsq_sck_gen.sv
module fsq_sck_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_field,
    input  logic             idle_level,
    output logic             sck,
    output logic             beat_end
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last_cnt;
    logic [DIV_W:0]   half;

    assign last_cnt = (div_field == '0) ? DIV_W'(1) : div_field;
    assign half     = ({1'b0, last_cnt} + (DIV_W+1)'(1)) >> 1;
    assign beat_end = run && (cnt == last_cnt);
    assign sck      = run ? ({1'b0, cnt} >= half) : idle_level;

    always_ff @(posedge clk) begin
        if (rst || !run || beat_end) cnt <= '0;
        else                         cnt <= cnt + DIV_W'(1);
    end

    // R2: the beat counter never passes the divisor limit
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt <= last_cnt);
    // R2: each new beat opens with the serial clock low
    a_r2_beat_opens_low: assert property (@(posedge clk) disable iff (rst)
        (run && $past(beat_end)) |-> !sck);
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
    import fsq_pkg::*;
#(
    parameter int WADDR_W = 30,
    parameter int DIV_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         cfg_mode,
    input  logic [1:0]         cfg_addr_sz,
    input  logic               cfg_wide_op,
    input  logic [3:0]         cfg_dummy,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_idle_high,
    input  logic [7:0]         cfg_opcode,
    input  logic [1:0]         cfg_ins_ln,
    input  logic [1:0]         cfg_adr_ln,
    input  logic [1:0]         cfg_dat_ln,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [WADDR_W-1:0] req_waddr,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data,
    output logic               sck,
    output logic               cs_req,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in
);
    localparam int BADDR_W = WADDR_W + 2;

    cfg_t             cfg_live;
    plan_t            plan_live, plan_q;
    phase_e           phase;
    logic [3:0]       dummy_q;
    logic [DIV_W-1:0] div_q;
    logic [5:0]       beat, last_idx, step;
    logic [31:0]      sh, rx, rx_next, addr_q;
    logic [1:0]       cur_lg;
    logic             run, beat_end, drive;

    always_comb begin
        cfg_live.mode    = cfg_mode;
        cfg_live.addr_sz = cfg_addr_sz;
        cfg_live.wide_op = cfg_wide_op;
        cfg_live.dummy   = cfg_dummy;
        cfg_live.opcode  = cfg_opcode;
        cfg_live.ins_ln  = cfg_ins_ln;
        cfg_live.adr_ln  = cfg_adr_ln;
        cfg_live.dat_ln  = cfg_dat_ln;
    end

    fsq_mode_decode u_decode (.cfg(cfg_live), .plan(plan_live));

    assign run = (phase != PH_IDLE);

    fsq_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk(clk), .rst(rst), .run(run), .div_field(div_q),
        .idle_level(cfg_idle_high), .sck(sck), .beat_end(beat_end)
    );

    always_comb begin
        unique case (phase)
            PH_INSTR: begin cur_lg = plan_q.ins_lg; last_idx = (6'd8 >> plan_q.ins_lg) - 6'd1; end
            PH_ADDR:  begin cur_lg = plan_q.adr_lg; last_idx = (plan_q.addr_bits >> plan_q.adr_lg) - 6'd1; end
            PH_DUMMY: begin cur_lg = 2'd0;          last_idx = {2'b00, dummy_q} + 6'd2; end
            PH_DATA:  begin cur_lg = plan_q.dat_lg; last_idx = (6'd32 >> plan_q.dat_lg) - 6'd1; end
            default:  begin cur_lg = 2'd0;          last_idx = 6'd0; end
        endcase
        step = 6'd1 << cur_lg;
    end

    // capture path: single line listens on line 1, wider phases on the low lines
    always_comb begin
        unique case (plan_q.dat_lg)
            2'd0:    rx_next = {rx[30:0], io_in[1]};
            2'd1:    rx_next = {rx[29:0], io_in[1:0]};
            default: rx_next = {rx[27:0], io_in};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            plan_q    <= '0;
            dummy_q   <= '0;
            div_q     <= '0;
            beat      <= '0;
            sh        <= '0;
            rx        <= '0;
            addr_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (phase == PH_IDLE) begin
                if (req_valid) begin
                    plan_q  <= plan_live;
                    dummy_q <= cfg_dummy;
                    div_q   <= cfg_div;
                    addr_q  <= 32'({req_waddr, 2'b00});
                    sh      <= {plan_live.opcode, 24'h0};
                    rx      <= '0;
                    beat    <= '0;
                    phase   <= PH_INSTR;
                end
            end else if (beat_end) begin
                if (phase == PH_DATA) rx <= rx_next;
                if (beat != last_idx) begin
                    beat <= beat + 6'd1;
                    sh   <= sh << step;
                end else begin
                    beat <= '0;
                    unique case (phase)
                        PH_INSTR: begin
                            phase <= PH_ADDR;
                            sh    <= addr_q << (6'd32 - plan_q.addr_bits);
                        end
                        PH_ADDR:  phase <= plan_q.has_dummy ? PH_DUMMY : PH_DATA;
                        PH_DUMMY: phase <= PH_DATA;
                        PH_DATA: begin
                            phase     <= PH_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_data  <= {rx_next[7:0], rx_next[15:8],
                                          rx_next[23:16], rx_next[31:24]};
                        end
                        default:  phase <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    assign req_ready = (phase == PH_IDLE);
    assign cs_req    = run;
    assign drive     = (phase == PH_INSTR) || (phase == PH_ADDR);

    always_comb begin
        io_out = '0;
        if (drive) begin
            unique case (cur_lg)
                2'd0:    io_out = {3'b000, sh[31]};
                2'd1:    io_out = {2'b00, sh[31:30]};
                default: io_out = sh[31:28];
            endcase
        end
    end

    for (genvar i = 0; i < 4; i++) begin : g_oe
        assign io_oe[i] = drive && (3'(i) < (3'd1 << cur_lg));
    end

    // R1: idle bus is quiet and the clock rests at the chosen level
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!cs_req && io_oe == 4'b0000 && sck == cfg_idle_high));
    // R7: lines are released through dummy and data beats
    a_r7_oe_released: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DUMMY || phase == PH_DATA) |-> io_oe == 4'b0000);
    // R10: response strobe is a single cycle
    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R10: response coincides with return to idle
    a_r10_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (req_ready && !cs_req));
    // R11: an accepted request makes the sequencer busy
    a_r11_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cs_req && !req_ready));
    // R7: dummy phase only appears in modes that call for it
    a_r7_dummy_mode: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DUMMY) |-> plan_q.has_dummy);
endmodule

// File: tb/flash_read_seq_bench.sv
`timescale 1ns/1ps
module flash_read_seq_bench;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  asz;
        logic        wide;
        logic [3:0]  dmy;
        logic [5:0]  div;
        logic        cpol;
        logic [7:0]  op;
        logic [1:0]  il, al, dl;
        logic [29:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd2, 1'b0, 4'd0,  6'd1, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0, 30'h0012345, 32'hA1B2C3D4},
        '{3'd1, 2'd2, 1'b0, 4'd5,  6'd2, 1'b1, 8'h00, 2'd0, 2'd0, 2'd0, 30'h3ABCDEF, 32'h0F1E2D3C},
        '{3'd2, 2'd2, 1'b0, 4'd0,  6'd1, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0, 30'h0000001, 32'h80000001},
        '{3'd3, 2'd3, 1'b1, 4'd2,  6'd3, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0, 30'h2468ACE, 32'h13579BDF},
        '{3'd4, 2'd1, 1'b0, 4'd15, 6'd1, 1'b1, 8'h00, 2'd0, 2'd0, 2'd0, 30'h0001234, 32'hFFFF0000},
        '{3'd5, 2'd3, 1'b0, 4'd1,  6'd1, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0, 30'h3FFFFFFF, 32'h5A5AA5A5},
        '{3'd6, 2'd0, 1'b0, 4'd0,  6'd1, 1'b0, 8'h5A, 2'd2, 2'd1, 2'd0, 30'h000002A, 32'hDEADBEEF},
        '{3'd7, 2'd2, 1'b1, 4'd0,  6'd4, 1'b1, 8'hC7, 2'd1, 2'd2, 2'd2, 30'h0155555, 32'h01234567},
        '{3'd0, 2'd3, 1'b1, 4'd0,  6'd0, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0, 30'h0ABCDEF, 32'hCAFEF00D},
        '{3'd6, 2'd1, 1'b0, 4'd0,  6'd1, 1'b0, 8'h9F, 2'd3, 2'd3, 2'd3, 30'h0000777, 32'h89ABCDEF}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_mode;
    logic [1:0]  cfg_addr_sz;
    logic        cfg_wide_op;
    logic [3:0]  cfg_dummy;
    logic [5:0]  cfg_div;
    logic        cfg_idle_high;
    logic [7:0]  cfg_opcode;
    logic [1:0]  cfg_ins_ln, cfg_adr_ln, cfg_dat_ln;
    logic        req_valid, req_ready;
    logic [29:0] req_waddr;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        sck, cs_req;
    logic [3:0]  io_out, io_oe, io_in;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flash_read_seq u_flash_read_seq (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_addr_sz(cfg_addr_sz),
        .cfg_wide_op(cfg_wide_op), .cfg_dummy(cfg_dummy), .cfg_div(cfg_div),
        .cfg_idle_high(cfg_idle_high), .cfg_opcode(cfg_opcode),
        .cfg_ins_ln(cfg_ins_ln), .cfg_adr_ln(cfg_adr_ln), .cfg_dat_ln(cfg_dat_ln),
        .req_valid(req_valid), .req_ready(req_ready), .req_waddr(req_waddr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sck(sck), .cs_req(cs_req),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // beat log: one entry per rising serial clock edge while selected
    logic [3:0] lg_out [2048];
    logic [3:0] lg_oe  [2048];
    int         log_n = 0;
    logic       prev_sck = 1'b0;

    always @(negedge clk) begin
        if (cs_req && sck && !prev_sck) begin
            lg_out[log_n & 2047] = io_out;
            lg_oe[log_n & 2047]  = io_oe;
            log_n = log_n + 1;
        end
        prev_sck = sck;
    end

    // flash model data source
    logic        txn_on = 1'b0;
    int          cur_base = 0, cur_nstart = 0, cur_dbeats = 0;
    int          cur_dn = 1;
    logic [31:0] cur_stream = '0;

    always_comb begin : drv
        int idx;
        logic [31:0] ch;
        io_in = 4'b0000;
        ch    = '0;
        idx   = log_n - cur_base - cur_nstart - 1;
        if (txn_on && idx >= 0 && idx < cur_dbeats) begin
            ch = (cur_stream >> (32 - (idx + 1) * cur_dn)) & ((32'd1 << cur_dn) - 1);
            if (cur_dn == 1) io_in[1] = ch[0];
            else             io_in = ch[3:0];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int lg_of(input logic [1:0] c);
        return (c == 2'd3) ? 2 : int'(c);
    endfunction

    task automatic plan_of(input vec_t v, output int il, output int al, output int dl,
                           output bit dm, output logic [7:0] op);
        bit w;
        w = v.wide && v.asz == 2'd3;
        il = 0; al = 0; dl = 0; dm = 1'b1;
        case (v.mode)
            3'd0: begin op = w ? 8'h13 : 8'h03; dm = 1'b0; end
            3'd1: op = w ? 8'h0C : 8'h0B;
            3'd2: begin op = w ? 8'h3C : 8'h3B; dl = 1; end
            3'd3: begin op = w ? 8'hBC : 8'hBB; al = 1; dl = 1; end
            3'd4: begin op = w ? 8'h6C : 8'h6B; dl = 2; end
            3'd5: begin op = w ? 8'hEC : 8'hEB; al = 2; dl = 2; end
            default: begin
                op = v.op; il = lg_of(v.il); al = lg_of(v.al); dl = lg_of(v.dl);
                dm = v.mode[0];
            end
        endcase
    endtask

    task automatic run_txn(input vec_t v, input bit scramble);
        int il, al, dl, ni, na, nd, nq, n, awb, dv, cyc, base, total;
        bit dm, ok;
        logic [7:0]  op;
        logic [31:0] ba, exp, got, g_e, g_a;
        string tag;
        plan_of(v, il, al, dl, dm, op);
        awb = 8 * (int'(v.asz) + 1);
        ni = 8 >> il; na = awb >> al; nd = dm ? int'(v.dmy) + 3 : 0; nq = 32 >> dl;
        dv = (v.div == 6'd0) ? 2 : int'(v.div) + 1;
        total = ni + na + nd + nq;
        cfg_mode = v.mode; cfg_addr_sz = v.asz; cfg_wide_op = v.wide; cfg_dummy = v.dmy;
        cfg_div = v.div; cfg_idle_high = v.cpol; cfg_opcode = v.op;
        cfg_ins_ln = v.il; cfg_adr_ln = v.al; cfg_dat_ln = v.dl;
        base = log_n;
        cur_base = base; cur_nstart = ni + na + nd; cur_dbeats = nq; cur_dn = 1 << dl;
        cur_stream = {v.data[7:0], v.data[15:8], v.data[23:16], v.data[31:24]};
        txn_on = 1'b1;
        req_waddr = v.addr; req_valid = 1'b1;
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (!scramble || cyc > 5) req_valid = 1'b0;
            if (scramble && cyc == 3) begin
                cfg_mode = ~v.mode; cfg_addr_sz = ~v.asz; cfg_dummy = ~v.dmy;
                cfg_div = 6'h3F; cfg_opcode = ~v.op; cfg_wide_op = ~v.wide;
                cfg_ins_ln = ~v.il; cfg_adr_ln = ~v.al; cfg_dat_ln = ~v.dl;
                req_waddr = ~v.addr;
            end
            if (rsp_valid) break;
            if (cyc > 20000) break;
        end
        chk(rsp_valid, "R10", "response seen before timeout", 32'(cyc), 32'(total * dv + 1));
        tag = (v.mode >= 3'd6) ? "R8" : ((v.wide && v.asz == 2'd3) ? "R4" : "R3");
        // opcode beats
        ok = 1'b1; g_e = '0; g_a = '0;
        n = 1 << il;
        for (int k = 0; k < ni; k++) begin
            exp = 32'((op >> (8 - (k + 1) * n)) & ((1 << n) - 1));
            got = 32'(lg_out[(base + k) & 2047] & 4'((1 << n) - 1));
            if (got != exp || lg_oe[(base + k) & 2047] != 4'((1 << n) - 1)) begin
                if (ok) begin g_a = got; g_e = exp; end
                ok = 1'b0;
            end
        end
        chk(ok, tag, "opcode beats", g_a, g_e);
        // address beats
        ok = 1'b1; g_e = '0; g_a = '0;
        ba = 32'({v.addr, 2'b00});
        if (awb < 32) ba = ba & ((32'd1 << awb) - 1);
        n = 1 << al;
        for (int k = 0; k < na; k++) begin
            exp = (ba >> (awb - (k + 1) * n)) & ((32'd1 << n) - 1);
            got = 32'(lg_out[(base + ni + k) & 2047] & 4'((1 << n) - 1));
            if (got != exp || lg_oe[(base + ni + k) & 2047] != 4'((1 << n) - 1)) begin
                if (ok) begin g_a = got; g_e = exp; end
                ok = 1'b0;
            end
        end
        chk(ok, (al > 0) ? "R6" : "R5", "address beats", g_a, g_e);
        // dummy and data beats have lines released
        ok = 1'b1; g_a = '0;
        for (int k = 0; k < nd + nq; k++)
            if (lg_oe[(base + ni + na + k) & 2047] != 4'b0000) begin
                ok = 1'b0; g_a = 32'(lg_oe[(base + ni + na + k) & 2047]);
            end
        chk(ok, "R7", "oe released after address", g_a, 32'h0);
        chk(log_n - base == total, "R7", "serial beat count", 32'(log_n - base), 32'(total));
        chk(cyc == total * dv + 1, "R2", "cycles to response", 32'(cyc), 32'(total * dv + 1));
        chk(rsp_data == v.data, (dl > 0) ? "R6/R9" : "R9", "read word", rsp_data, v.data);
        chk(req_ready && !cs_req, "R10", "idle at response", {30'h0, req_ready, cs_req}, 32'h2);
        @(negedge clk);
        chk(!rsp_valid, "R10", "strobe lasts one cycle", 32'(rsp_valid), 32'h0);
        chk(sck == v.cpol && io_oe == 4'b0000, "R1", "idle clock level",
            {27'h0, io_oe, sck}, {31'h0, v.cpol});
        txn_on = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        rst = 1'b1; req_valid = 1'b0; req_waddr = '0;
        cfg_mode = '0; cfg_addr_sz = 2'd2; cfg_wide_op = 1'b0; cfg_dummy = '0;
        cfg_div = 6'd1; cfg_idle_high = 1'b0; cfg_opcode = '0;
        cfg_ins_ln = '0; cfg_adr_ln = '0; cfg_dat_ln = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!cs_req && req_ready && io_oe == 4'b0000 && !sck && !rsp_valid, "R1", "reset state",
            {26'h0, cs_req, req_ready, io_oe[1:0], sck, rsp_valid}, 32'h10);
        cfg_idle_high = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R1", "mode 3 idle level", 32'(sck), 32'h1);

        for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0);

        // R11: config and address scrambled and request held during a transaction
        v = VECS[3];
        run_txn(v, 1'b1);
        v = VECS[7];
        run_txn(v, 1'b1);

        // R2: slowest divider, short quad-output read
        v = '{3'd4, 2'd0, 1'b0, 4'd0, 6'd63, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0, 30'h0000011, 32'h76543210};
        run_txn(v, 1'b0);

        // R7/R8: custom fast with all single lines and maximum dummy count
        v = '{3'd7, 2'd3, 1'b0, 4'd15, 6'd1, 1'b1, 8'hE1, 2'd0, 2'd0, 2'd0, 30'h1234567, 32'h0BADCAFE};
        run_txn(v, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule